// File: doc/BRIEF.md
# Remote I/O Expander Register Bank

This block is the register side of a serially controlled 8-pin I/O expander. A serial target engine decodes the bus protocol and hands this block three kinds of strobe: a command byte that picks one of four registers, a data byte to be written into the picked register, and a capture pulse that arrives on the acknowledge clock of each byte read back to the host. The block keeps the register pointer, the output, polarity-inversion and direction registers, and the sampled input register. It returns the read byte and drives the port pins.

Each pin has an output enable and a drive value. Pin 0 is open-drain: it can only pull low. Pins 1 to 7 are push-pull. Port inputs pass through a two-flop synchronizer before they are captured. The pointer stays where the last command byte put it, so a host can stream writes or reads to one register without resending the command.

Top module: `pexp_regbank`

## Requirements
- R1: While and after reset (rst_n low), output = 0x00, polarity = 0xF0, direction = 0xFF, pointer = input register (0) and input register = 0x00. Every pin_oe bit is 0 and pin_out is 0x00.
- R2: A command byte selects a register by bits 1:0 alone: 0 input, 1 output, 2 polarity, 3 direction. Bits 7:2 are ignored.
- R3: The pointer changes only on a command strobe. Successive data writes and reads all go to the same register, with no auto-increment.
- R4: A data strobe updates the selected register in the first cycle after the strobe. A data strobe while the input register is selected changes no register.
- R5: A direction bit of 1 makes pin_oe for that pin 0. A bit of 0 enables the driver, subject to R7.
- R6: For pins 1 to 7 configured as outputs, pin_oe is 1 and pin_out equals the output-register bit.
- R7: Pin 0 has pin_oe = 1 only when it is configured as an output and its output bit is 0. pin_out bit 0 is always 0.
- R8: A read of the output register returns the stored flop value, not the pin level.
- R9: On a capture strobe the input register loads the synchronized pin levels, whatever each pin's direction. With no strobe it holds its value.
- R10: A read of the input register returns each bit XOR the polarity bit for that pin.
- R11: A pin change is seen by a capture on the third rising edge after the change, and not by captures on the first or second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte; bits 1:0 select the register |
| wr_valid | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte to write |
| rd_capture | input | 1 | Capture strobe on the acknowledge clock of a read byte |
| rd_data | output | 8 | Read value of the selected register |
| pin_in | input | 8 | Port pin levels |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin drive value |

## Verification
The bench streams several writes after one command byte. A design that auto-increments the pointer would put later bytes into the wrong register. It sends command bytes with the upper bits set, which would select a nonexistent register if those bits were decoded. It writes while the input register is selected, which a faulty decoder would let land in the output register. It steps pin 0 between low output, high output and input, where a push-pull pin 0 would drive high. It also times captures one and two edges after a pin change to expose a synchronizer that is too short or too long.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
    localparam int unsigned PEXP_W = 8;

    typedef enum logic [1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_CFG = 2'd3
    } sel_e;
endpackage

// File: rtl/pexp_sync.sv
module pexp_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q[STAGES-1];
endmodule

// File: rtl/pexp_regfile.sv
module pexp_regfile #(
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] OUT_RST = '0,
    parameter logic [W-1:0] POL_RST = '0,
    parameter logic [W-1:0] CFG_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  pexp_pkg::sel_e   cmd_sel,
    input  logic             wr_valid,
    input  logic [W-1:0]     wr_data,
    input  logic             cap_valid,
    input  logic [W-1:0]     pins_sync,
    output logic [1:0]       sel_q,
    output logic [W-1:0]     out_q,
    output logic [W-1:0]     pol_q,
    output logic [W-1:0]     cfg_q,
    output logic [W-1:0]     in_q,
    output logic [W-1:0]     rd_data
);
    typedef struct packed {
        pexp_pkg::sel_e sel;
        logic [W-1:0]   outp;
        logic [W-1:0]   pol;
        logic [W-1:0]   cfg;
        logic [W-1:0]   inp;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_valid) begin
            case (bank_q.sel)
                pexp_pkg::SEL_OUT: bank_d.outp = wr_data;
                pexp_pkg::SEL_POL: bank_d.pol  = wr_data;
                pexp_pkg::SEL_CFG: bank_d.cfg  = wr_data;
                default:           ;
            endcase
        end
        if (cmd_valid) bank_d.sel = cmd_sel;
        if (cap_valid) bank_d.inp = pins_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.sel  <= pexp_pkg::SEL_IN;
            bank_q.outp <= OUT_RST;
            bank_q.pol  <= POL_RST;
            bank_q.cfg  <= CFG_RST;
            bank_q.inp  <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        case (bank_q.sel)
            pexp_pkg::SEL_IN:  rd_data = bank_q.inp ^ bank_q.pol;
            pexp_pkg::SEL_OUT: rd_data = bank_q.outp;
            pexp_pkg::SEL_POL: rd_data = bank_q.pol;
            default:           rd_data = bank_q.cfg;
        endcase
    end

    assign sel_q = bank_q.sel;
    assign out_q = bank_q.outp;
    assign pol_q = bank_q.pol;
    assign cfg_q = bank_q.cfg;
    assign in_q  = bank_q.inp;
endmodule

// File: rtl/pexp_pindrv.sv
module pexp_pindrv #(
    parameter int unsigned  W       = 8,
    parameter logic [W-1:0] OD_MASK = 1
) (
    input  logic [W-1:0] cfg,
    input  logic [W-1:0] outv,
    output logic [W-1:0] oe,
    output logic [W-1:0] val
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        if (OD_MASK[i]) begin : g_od
            assign oe[i]  = ~cfg[i] & ~outv[i];
            assign val[i] = 1'b0;
        end else begin : g_pp
            assign oe[i]  = ~cfg[i];
            assign val[i] = outv[i];
        end
    end
endmodule

// File: rtl/pexp_regbank.sv
module pexp_regbank #(
    parameter int unsigned  W        = pexp_pkg::PEXP_W,
    parameter int unsigned  SYNC_STG = 2,
    parameter logic [W-1:0] OD_MASK  = 1,
    parameter logic [W-1:0] OUT_RST  = '0,
    parameter logic [W-1:0] POL_RST  = {{(W/2){1'b1}}, {(W-W/2){1'b0}}},
    parameter logic [W-1:0] CFG_RST  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [7:0]   cmd_byte,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         rd_capture,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    logic [W-1:0] sync_q;
    logic [1:0]   sel_q;
    logic [W-1:0] out_q, pol_q, cfg_q, in_q;
    logic         unused_cmd_hi;

    assign unused_cmd_hi = ^cmd_byte[7:2];

    pexp_sync #(.W(W), .STAGES(SYNC_STG)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_q)
    );

    pexp_regfile #(
        .W(W), .OUT_RST(OUT_RST), .POL_RST(POL_RST), .CFG_RST(CFG_RST)
    ) i_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_sel   (pexp_pkg::sel_e'(cmd_byte[1:0])),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .cap_valid (rd_capture),
        .pins_sync (sync_q),
        .sel_q     (sel_q),
        .out_q     (out_q),
        .pol_q     (pol_q),
        .cfg_q     (cfg_q),
        .in_q      (in_q),
        .rd_data   (rd_data)
    );

    pexp_pindrv #(.W(W), .OD_MASK(OD_MASK)) i_pindrv (
        .cfg  (cfg_q),
        .outv (out_q),
        .oe   (pin_oe),
        .val  (pin_out)
    );
endmodule

// File: rtl/pexp_regbank_chk.sv
module pexp_regbank_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic         wr_valid,
    input logic [W-1:0] wr_data,
    input logic         rd_capture,
    input logic [W-1:0] pin_oe,
    input logic [1:0]   sel_q,
    input logic [W-1:0] out_q,
    input logic [W-1:0] cfg_q,
    input logic [W-1:0] in_q,
    input logic [W-1:0] sync_q
);
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(sel_q));

    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && sel_q == 2'd1) |=> (out_q == $past(wr_data)));

    a_r4_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && sel_q == 2'd0 && !rd_capture) |=> ($stable(in_q) && $stable(out_q) && $stable(cfg_q)));

    a_r5_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pin_oe & cfg_q) == 0);

    a_r9_capture_sync: assert property (@(posedge clk) disable iff (!rst_n)
        rd_capture |=> (in_q == $past(sync_q)));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_capture |=> $stable(in_q));
endmodule

bind pexp_regbank pexp_regbank_chk #(.W(W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .rd_capture (rd_capture),
    .pin_oe     (pin_oe),
    .sel_q      (sel_q),
    .out_q      (out_q),
    .cfg_q      (cfg_q),
    .in_q       (in_q),
    .sync_q     (sync_q)
);

// File: tb/test_pexp_regbank.sv
module test_pexp_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_capture = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pexp_regbank i_pexp_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .rd_capture (rd_capture),
        .rd_data    (rd_data),
        .pin_in     (pin_in),
        .pin_oe     (pin_oe),
        .pin_out    (pin_out)
    );

    // op: 0 none, 1 command, 2 data write
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] arg;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{2'd1, 8'h03, 8'hFF},  // R1 direction default via select 3
        '{2'd2, 8'h0F, 8'h0F},  // R4 write lands next cycle
        '{2'd2, 8'hA5, 8'hA5},  // R3 second write, same register
        '{2'd1, 8'h02, 8'hF0},  // R1 polarity default
        '{2'd2, 8'h3C, 8'h3C},  // R4 polarity write
        '{2'd1, 8'hFD, 8'h00},  // R2 upper bits ignored, output selected
        '{2'd2, 8'h5A, 8'h5A},  // R4 output write
        '{2'd1, 8'h00, 8'h3C},  // R10 input 00 read through polarity 3C
        '{2'd2, 8'hFF, 8'h3C},  // R4 write to input register ignored
        '{2'd1, 8'h01, 8'h5A},  // R4 output untouched by ignored write
        '{2'd1, 8'h07, 8'hA5},  // R2 upper bits ignored, direction selected
        '{2'd0, 8'h00, 8'hA5}   // R3 pointer persists
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [7:0] arg);
        cmd_valid = (op == 2'd1);
        cmd_byte  = arg;
        wr_valid  = (op == 2'd2);
        wr_data   = arg;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        wr_valid  = 1'b0;
    endtask

    task automatic capture();
        rd_capture = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_capture = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 state during reset
        check("R1 oe in reset", pin_oe, 8'h00);
        check("R1 pin_out in reset", pin_out, 8'h00);
        check("R1 read input in reset", rd_data, 8'hF0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after reset", pin_oe, 8'h00);

        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k].op, VEC[k].arg);
            check($sformatf("vector %0d (R2/R3/R4/R10)", k), rd_data, VEC[k].exp);
        end

        // direction A5, output 5A: pins 1,3,4,6 drive; pin 0 is input
        check("R5 oe mixed direction", pin_oe, 8'h5A);
        check("R6 push-pull values", pin_out, 8'h5A);
        step(2'd2, 8'h00);
        check("R7 pin0 output low pulls", pin_oe, 8'hFF);
        step(2'd1, 8'h01);
        step(2'd2, 8'h5B);
        check("R7 pin0 output high released", pin_oe, 8'hFE);
        check("R7 pin0 never driven high", pin_out, 8'h5A);
        step(2'd2, 8'h00);
        check("R6 push-pull low", pin_out, 8'h00);
        step(2'd2, 8'h5B);

        // R8: pins differ from the output flops
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        check("R8 output read is flop", rd_data, 8'h5B);

        // R9 and R11: capture timing through synchronizer, pol 3C, pins outputs
        step(2'd1, 8'h00);
        check("R9 input baseline", rd_data, 8'h3C);
        pin_in = 8'hC3;
        capture();
        check("R11 first edge not seen", rd_data, 8'h3C);
        capture();
        check("R11 second edge not seen", rd_data, 8'h3C);
        capture();
        check("R11 third edge seen", rd_data, 8'hFF);

        // R10: polarity cleared
        step(2'd1, 8'h02);
        step(2'd2, 8'h00);
        step(2'd1, 8'h00);
        check("R10 no inversion", rd_data, 8'hC3);

        // R9: holds without capture
        pin_in = 8'h11;
        repeat (4) @(negedge clk);
        check("R9 hold without capture", rd_data, 8'hC3);
        capture();
        capture();
        capture();
        check("R9 capture new pins", rd_data, 8'h11);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 oe after mid reset", pin_oe, 8'h00);
        check("R1 read input after mid reset", rd_data, 8'hF0);
        rst_n = 1'b1;
        @(negedge clk);
        step(2'd1, 8'h01);
        check("R1 output default", rd_data, 8'h00);
        step(2'd1, 8'h03);
        check("R1 direction default", rd_data, 8'hFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule